// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopper

This block sequences the switches of one full bridge so that winding current is held near a trip level. While enabled it turns on the diagonal pair chosen by a direction input. When a sampled current comparator reports that the trip level has been reached, the block starts an off-time of fixed length and then returns to the drive phase. During the off-time the winding current decays, either quickly through the opposite diagonal or slowly through both low-side switches, and synchronous rectification keeps the conducting switches on. A zero-current flag turns rectification off so that the winding current cannot reverse.

A build-time parameter selects the bridge type. A stepper bridge always runs mixed decay: a fast portion, then a short all-off gap, then a slow portion for the rest of the off-time. A DC bridge runs only fast decay or only slow decay for the whole off-time, as chosen by a select input. For a few ticks after each drive phase starts, the comparator is ignored so that switching transients cannot end the phase early. The stepper and DC bridge types use different lengths for this blanking window. All durations are counted in ticks of the block clock.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high or `en` is low, all four gate outputs and `sr_en` are 0 in that same cycle. After `en` returns high, the first cycle in the drive phase is followed by a full blanking window.
- R2: In the drive phase, `dir`=1 gives `hi_a`=1 and `lo_b`=1, and `dir`=0 gives `hi_b`=1 and `lo_a`=1. The other outputs, `sr_en` included, are 0.
- R3: For the first BLANK_STEP ticks (stepper bridge) or BLANK_DC ticks (DC bridge) of each drive phase, `trip` has no effect. A `trip` sampled in any later drive-phase tick starts the off-time in the next cycle.
- R4: Every off-time lasts exactly OFF_TICKS cycles and is then followed by a drive phase.
- R5: A stepper bridge spends the first FAST_TICKS cycles of the off-time in fast decay. This uses the reverse diagonal (`hi_b`+`lo_a` after a trip with `dir`=1, `hi_a`+`lo_b` after a trip with `dir`=0) with `sr_en`=1. It then spends the rest of the off-time, after the dead time, in slow decay (`lo_a`+`lo_b` with `sr_en`=1).
- R6: A DC bridge spends the whole off-time in slow decay if `mode_slow` was 1 at the accepted trip, or in fast decay if it was 0. A stepper bridge ignores `mode_slow`.
- R7: A `zero_cur` sampled high during the off-time makes all gate outputs and `sr_en` 0 from the next cycle until the off-time ends.
- R8: `hi_a` and `lo_a` are never 1 in the same cycle, and `hi_b` and `lo_b` are never 1 in the same cycle.
- R9: Between fast and slow decay, a stepper bridge holds every gate output and `sr_en` at 0 for DEAD_TICKS cycles.
- R10: The decay pattern follows the value of `dir` sampled with the accepted trip. A change of `dir` during the off-time does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable; low forces gates off and idles the sequencer |
| dir | input | 1 | Drive direction for the active diagonal |
| trip | input | 1 | Sampled current comparator, high at or above trip level |
| mode_slow | input | 1 | DC bridge decay select, 1 = slow, 0 = fast |
| zero_cur | input | 1 | Load current has reached zero |
| hi_a | output | 1 | High-side gate enable, half bridge A |
| lo_a | output | 1 | Low-side gate enable, half bridge A |
| hi_b | output | 1 | High-side gate enable, half bridge B |
| lo_b | output | 1 | Low-side gate enable, half bridge B |
| sr_en | output | 1 | Synchronous rectification active |

## Verification
Two events can fall in the same cycle: a zero-current report and the boundary where the decay phase changes, whether fast to dead time, dead time to slow, or the last off tick back to drive. The bench moves a one-cycle `zero_cur` pulse across every position of the off-time of a stepper bridge while a DC bridge runs alongside. It judges each cycle against a model in which the zero flag takes effect in the next cycle and is dropped when the following off-time begins. A second sweep moves a single `trip` pulse across every tick of the blanking window, to catch the cycle where blanking ends and a trip is first accepted.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ON,
        PH_FAST,
        PH_DEAD,
        PH_SLOW
    } chop_ph_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
        logic sr;
    } gate_t;

    function automatic logic in_off(input chop_ph_e p);
        return (p == PH_FAST) || (p == PH_DEAD) || (p == PH_SLOW);
    endfunction

endpackage

// File: rtl/chop_blank.sv
module chop_blank #(
    parameter int unsigned BLANK = 10,
    localparam int unsigned BW = $clog2(BLANK + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= BW'(BLANK);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
    import chop_pkg::*;
#(
    parameter int unsigned OFF_TICKS  = 300,
    parameter int unsigned FAST_TICKS = 90,
    parameter int unsigned DEAD_TICKS = 6,
    parameter bit          IS_DC      = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     trip,
    input  logic     blank_busy,
    input  logic     mode_slow,
    input  logic     dir,
    input  logic     zero_cur,
    output chop_ph_e st,
    output logic     dir_q,
    output logic     zero_seen,
    output logic     start_on
);
    localparam int unsigned TW = $clog2(OFF_TICKS + 1);
    localparam logic [TW-1:0] LAST_OFF = TW'(OFF_TICKS - 1);
    localparam logic [TW-1:0] FAST_END = TW'(FAST_TICKS - 1);
    localparam logic [TW-1:0] DEAD_END = TW'(FAST_TICKS + DEAD_TICKS - 1);
    localparam bit MIXED = !IS_DC;

    chop_ph_e      nxt;
    chop_ph_e      first_ph;
    logic [TW-1:0] tcnt;
    logic          trip_ok;

    generate
        if (IS_DC) begin : g_dc
            assign first_ph = mode_slow ? PH_SLOW : PH_FAST;
        end else begin : g_step
            assign first_ph = PH_FAST;
        end
    endgenerate

    assign trip_ok = (st == PH_ON) && !blank_busy && trip;

    always_comb begin
        nxt = st;
        if (!en) begin
            nxt = PH_IDLE;
        end else begin
            case (st)
                PH_IDLE: nxt = PH_ON;
                PH_ON:   if (trip_ok) nxt = first_ph;
                PH_FAST: begin
                    if (MIXED && tcnt == FAST_END) nxt = PH_DEAD;
                    else if (tcnt == LAST_OFF)     nxt = PH_ON;
                end
                PH_DEAD: if (tcnt == DEAD_END) nxt = PH_SLOW;
                PH_SLOW: if (tcnt == LAST_OFF) nxt = PH_ON;
                default: nxt = PH_IDLE;
            endcase
        end
    end

    assign start_on = (nxt == PH_ON) && (st != PH_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_IDLE;
            tcnt      <= '0;
            dir_q     <= 1'b0;
            zero_seen <= 1'b0;
        end else begin
            st <= nxt;
            if (trip_ok) begin
                tcnt      <= '0;
                dir_q     <= dir;
                zero_seen <= 1'b0;
            end else if (in_off(st)) begin
                tcnt <= tcnt + 1'b1;
                if (zero_cur) zero_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chop_gates.sv
module chop_gates
    import chop_pkg::*;
(
    input  logic     en,
    input  chop_ph_e st,
    input  logic     dir,
    input  logic     dir_q,
    input  logic     zero_seen,
    output gate_t    g
);
    always_comb begin
        g = '0;
        if (en) begin
            case (st)
                PH_ON: begin
                    if (dir) begin
                        g.hi_a = 1'b1;
                        g.lo_b = 1'b1;
                    end else begin
                        g.hi_b = 1'b1;
                        g.lo_a = 1'b1;
                    end
                end
                PH_FAST: begin
                    if (!zero_seen) begin
                        g.sr = 1'b1;
                        if (dir_q) begin
                            g.hi_b = 1'b1;
                            g.lo_a = 1'b1;
                        end else begin
                            g.hi_a = 1'b1;
                            g.lo_b = 1'b1;
                        end
                    end
                end
                PH_SLOW: begin
                    if (!zero_seen) begin
                        g.sr   = 1'b1;
                        g.lo_a = 1'b1;
                        g.lo_b = 1'b1;
                    end
                end
                default: g = '0;
            endcase
        end
    end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned OFF_TICKS  = 300,
    parameter int unsigned FAST_TICKS = 90,
    parameter int unsigned DEAD_TICKS = 6,
    parameter int unsigned BLANK_STEP = 10,
    parameter int unsigned BLANK_DC   = 30,
    parameter bit          IS_DC      = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dir,
    input  logic trip,
    input  logic mode_slow,
    input  logic zero_cur,
    output logic hi_a,
    output logic lo_a,
    output logic hi_b,
    output logic lo_b,
    output logic sr_en
);
    localparam int unsigned BLANK = IS_DC ? BLANK_DC : BLANK_STEP;

    chop_ph_e st;
    logic     blank_busy;
    logic     start_on;
    logic     dir_q;
    logic     zero_seen;
    gate_t    g;

    chop_blank #(.BLANK(BLANK)) u_blank (
        .clk  (clk),
        .rst  (rst),
        .load (start_on),
        .busy (blank_busy)
    );

    chop_seq #(
        .OFF_TICKS  (OFF_TICKS),
        .FAST_TICKS (FAST_TICKS),
        .DEAD_TICKS (DEAD_TICKS),
        .IS_DC      (IS_DC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .trip       (trip),
        .blank_busy (blank_busy),
        .mode_slow  (mode_slow),
        .dir        (dir),
        .zero_cur   (zero_cur),
        .st         (st),
        .dir_q      (dir_q),
        .zero_seen  (zero_seen),
        .start_on   (start_on)
    );

    chop_gates u_gates (
        .en        (en && !rst),
        .st        (st),
        .dir       (dir),
        .dir_q     (dir_q),
        .zero_seen (zero_seen),
        .g         (g)
    );

    assign hi_a  = g.hi_a;
    assign lo_a  = g.lo_a;
    assign hi_b  = g.hi_b;
    assign lo_b  = g.lo_b;
    assign sr_en = g.sr;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk
    import chop_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     en,
    input logic     zero_cur,
    input logic     hi_a,
    input logic     lo_a,
    input logic     hi_b,
    input logic     lo_b,
    input logic     sr_en,
    input chop_ph_e st,
    input logic     blank_busy
);
    assert_half_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(hi_a && lo_a) && !(hi_b && lo_b));

    assert_en_off_R1: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(hi_a || lo_a || hi_b || lo_b || sr_en));

    assert_gap_before_slow_R9: assert property (@(posedge clk) disable iff (rst)
        (sr_en && (hi_a || hi_b)) |=> !(sr_en && lo_a && lo_b));

    assert_zero_stops_sr_R7: assert property (@(posedge clk) disable iff (rst)
        (sr_en && zero_cur && en) |=> !sr_en);

    assert_blank_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_ON && blank_busy && en) |=> (st == PH_ON));
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .zero_cur   (zero_cur),
    .hi_a       (hi_a),
    .lo_a       (lo_a),
    .hi_b       (hi_b),
    .lo_b       (lo_b),
    .sr_en      (sr_en),
    .st         (st),
    .blank_busy (blank_busy)
);

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OFF = 20;
    localparam int FT  = 6;
    localparam int DT  = 2;
    localparam int BS  = 3;
    localparam int BD  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, dir = 1'b1, trip = 1'b0, mode_slow = 1'b0, zero_cur = 1'b0;
    logic s_hi_a, s_lo_a, s_hi_b, s_lo_b, s_sr;
    logic d_hi_a, d_lo_a, d_hi_b, d_lo_b, d_sr;
    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chop_ctrl #(.OFF_TICKS(OFF), .FAST_TICKS(FT), .DEAD_TICKS(DT),
                .BLANK_STEP(BS), .BLANK_DC(BD), .IS_DC(1'b0)) u0 (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip),
        .mode_slow(mode_slow), .zero_cur(zero_cur),
        .hi_a(s_hi_a), .lo_a(s_lo_a), .hi_b(s_hi_b), .lo_b(s_lo_b), .sr_en(s_sr));

    chop_ctrl #(.OFF_TICKS(OFF), .FAST_TICKS(FT), .DEAD_TICKS(DT),
                .BLANK_STEP(BS), .BLANK_DC(BD), .IS_DC(1'b1)) u1 (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip),
        .mode_slow(mode_slow), .zero_cur(zero_cur),
        .hi_a(d_hi_a), .lo_a(d_lo_a), .hi_b(d_hi_b), .lo_b(d_lo_b), .sr_en(d_sr));

    // vector order {hi_a, lo_a, hi_b, lo_b, sr_en}
    function automatic logic [4:0] got_of(input bit dc);
        return dc ? {d_hi_a, d_lo_a, d_hi_b, d_lo_b, d_sr}
                  : {s_hi_a, s_lo_a, s_hi_b, s_lo_b, s_sr};
    endfunction

    // phase code: 1 drive, 2 fast, 3 dead, 4 slow
    function automatic int phase_of(input bit dc, input int pos, input bit m);
        int b = dc ? BD : BS;
        int j = pos - (b + 1);
        if (pos <= b) return 1;
        if (dc) return m ? 4 : 2;
        if (j < FT) return 2;
        if (j < FT + DT) return 3;
        return 4;
    endfunction

    function automatic logic [4:0] exp_of(input bit dc, input int pos,
                                          input bit d, input bit m, input bit zl);
        case (phase_of(dc, pos, m))
            1: return d ? 5'b10010 : 5'b01100;
            2: return zl ? 5'b00000 : (d ? 5'b01101 : 5'b10011);
            4: return zl ? 5'b00000 : 5'b01011;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic restart();
        en = 1'b0; trip = 1'b0; zero_cur = 1'b0;
        tick();
        en = 1'b1;
        tick();
    endtask

    task automatic run(input bit d, input bit m, input int zpos, input int n);
        bit zl [2];
        dir = d; mode_slow = m;
        zl[0] = 1'b0; zl[1] = 1'b0;
        restart();
        for (int c = 0; c < n; c++) begin
            for (int k = 0; k < 2; k++) begin
                int b = (k == 1) ? BD : BS;
                int pos = c % (b + 1 + OFF);
                int ph = phase_of(k == 1, pos, m);
                string tg;
                logic [4:0] gv;
                if (pos == b + 1) zl[k] = 1'b0;
                if (ph == 1) tg = (pos == 0 && c > 0) ? "R4" : "R2";
                else if (zl[k] && ph != 3) tg = "R7";
                else if (k == 1) tg = "R6";
                else if (ph == 3) tg = "R9";
                else tg = "R5";
                gv = got_of(k == 1);
                check(tg, gv, exp_of(k == 1, pos, d, m, zl[k]));
                check("R8", {gv[4] & gv[3], gv[2] & gv[1]}, 2'b00);
            end
            zero_cur = (c == zpos);
            trip = 1'b1;
            for (int k = 0; k < 2; k++) begin
                int b = (k == 1) ? BD : BS;
                int pos = c % (b + 1 + OFF);
                if (pos >= b + 1 && zero_cur) zl[k] = 1'b1;
            end
            tick();
        end
        trip = 1'b0; zero_cur = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        // R1: reset and disabled state
        tick(); tick();
        check("R1", got_of(1'b0), 5'b00000);
        check("R1", got_of(1'b1), 5'b00000);
        rst = 1'b0;
        tick();
        check("R1", got_of(1'b0), 5'b00000);
        check("R1", got_of(1'b1), 5'b00000);

        // free-running chop cycles, both directions, both mode values
        run(1'b1, 1'b1, -1, 2 * (BD + 1 + OFF) + 2);
        run(1'b0, 1'b1, -1, 2 * (BD + 1 + OFF) + 2);
        run(1'b1, 1'b0, -1, 2 * (BD + 1 + OFF) + 2);
        run(1'b0, 1'b0, -1, 2 * (BD + 1 + OFF) + 2);

        // R7: zero-current pulse swept across the stepper off-time
        for (int z = 0; z < OFF; z++)
            run(1'b1, 1'b1, BS + 1 + z, BS + 1 + OFF + 3);
        run(1'b0, 1'b0, BD + 1 + 4, BD + 1 + OFF + 3);
        run(1'b1, 1'b1, BD + 1 + 9, BD + 1 + OFF + 3);

        // R3: single trip pulse swept across the blanking window
        for (int p = 0; p <= BD + 1; p++) begin
            dir = 1'b1; mode_slow = 1'b1;
            restart();
            for (int i = 0; i < p; i++) tick();
            trip = 1'b1;
            tick();
            trip = 1'b0;
            check("R3", got_of(1'b0), (p >= BS) ? 5'b01101 : 5'b10010);
            check("R3", got_of(1'b1), (p >= BD) ? 5'b01011 : 5'b10010);
        end

        // R1: enable low during fast decay forces outputs off at once
        dir = 1'b1; mode_slow = 1'b0;
        restart();
        trip = 1'b1;
        for (int i = 0; i < BS + 1; i++) tick();
        check("R5", got_of(1'b0), 5'b01101);
        en = 1'b0;
        #1;
        check("R1", got_of(1'b0), 5'b00000);
        check("R1", got_of(1'b1), 5'b00000);
        tick();
        check("R1", got_of(1'b0), 5'b00000);
        en = 1'b1;
        tick();
        check("R1", got_of(1'b0), 5'b10010);
        for (int i = 0; i < BS; i++) tick();
        check("R1", got_of(1'b0), 5'b10010);
        tick();
        check("R1", got_of(1'b0), 5'b01101);

        // R10: direction change during off-time does not alter decay
        dir = 1'b1;
        restart();
        trip = 1'b1;
        for (int i = 0; i < BS + 1; i++) tick();
        dir = 1'b0;
        tick();
        check("R10", got_of(1'b0), 5'b01101);
        trip = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule